// File: doc/BRIEF.md
# Split-Accumulator Transposed FIR Filter

A fixed-coefficient FIR filter in transposed direct form. Each accepted input sample is multiplied by every coefficient in the same cycle. The constant multipliers are built only from shifts and adds. The products are added into partial sums that move one register stage per accepted sample toward the output.

The stages nearest the input hold the partial sum at full width. From a configurable boundary tap onward, the partial sum travels as two fields:

- a high field, which passes through the stage unchanged;
- a low field of `KSPLIT` bits, which is the only field the product is added into.

At each split stage the signed carry or borrow out of the low-field add (−1, 0 or +1) goes into its own 2-bit register. Those carries ride along the line. The output stage folds all of them into the high field in one step, adds the last product, and produces the full-precision result.

Top module: `fir_split_tdf`

## Requirements
- R1: While `rst_n` is low at a clock edge, every partial-sum, low-field, high-field and carry register and the output are cleared. After that edge `out_vld` is 0 and `out_y` is 0, and no sample taken before the reset contributes to any later output.
- R2: `out_vld` is 1 in exactly the cycle after a cycle with `in_vld` high, and 0 otherwise.
- R3: On each valid output, `out_y` equals the sum over k = 0..7 of c[k]·x[n−k] at full precision (19-bit two's complement). Here x[n] is the current valid sample and x[n−k] is the k-th earlier valid sample, taken as 0 before the first sample after reset.
- R4: With `in_vld` low, the delay line does not advance, and `out_y` keeps its last value. Gaps between valid samples do not change any later result.
- R5: A low-field add whose product is negative and larger than the low field borrows correctly from the high field. Every stored carry is one of the 2-bit two's-complement codes 11, 00 or 01, and never 10.
- R6: A unit impulse produces the coefficients in tap order. The default set is c[0..7] = 9, −1, 45, 127, −128, 20, −7, 3, and c[k] appears k valid samples after the impulse.
- R7: Full-scale inputs (−128 and +127) against full-scale coefficients give exact results without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Sample strobe; the line advances only when high |
| in_x | input | 8 | Signed input sample |
| out_vld | output | 1 | Output strobe, one cycle after `in_vld` |
| out_y | output | 19 | Signed full-precision filter output |

## Verification
Unit impulses of +1 and −128 show each coefficient alone at its own delay, which separates tap-order and multiplier faults.

A ramp through all 256 input codes and a held step at every code drive the low fields across both carry and borrow boundaries. Alternating full-scale values stress the widest sums and the worst borrows.

A long pseudo-random stream with random idle cycles checks that gaps neither advance the line nor disturb the output. A reset in mid-stream followed by an impulse shows that no old state leaks through.

// File: rtl/tdf_split_pkg.sv
`timescale 1ns/1ps
// Package: shared arithmetic for the split-accumulator FIR.
// Assumes coefficient width <= 32 and input width <= 32.
package tdf_split_pkg;

    // Constant multiply as a sum of shifted copies; the top coefficient
    // bit carries negative weight (two's complement).
    function automatic logic signed [63:0] shift_add_mul(
        input logic signed [31:0] x,
        input logic signed [31:0] c,
        input int                 cw
    );
        logic signed [63:0] acc;
        acc = '0;
        for (int i = 0; i < cw; i++) begin
            if (c[i]) begin
                if (i == cw - 1) acc = acc - (64'(x) <<< i);
                else             acc = acc + (64'(x) <<< i);
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/tsplit_cmul.sv
`timescale 1ns/1ps
// Module: tsplit_cmul
// Fixed-coefficient multiplier built from shifts and adds.
// Assumes PW = DW + CW, so the product never wraps.
module tsplit_cmul #(
    parameter int DW = 8,
    parameter int CW = 8,
    parameter int PW = 16,
    parameter logic [CW-1:0] COEF_T = '0
) (
    input  logic signed [DW-1:0] x,
    output logic signed [PW-1:0] p
);
    import tdf_split_pkg::*;

    localparam logic signed [CW-1:0] CS = COEF_T;

    // product of the live sample with this tap's constant
    assign p = PW'(shift_add_mul(32'(x), 32'(CS), CW));
endmodule

// File: rtl/tsplit_full_tap.sv
`timescale 1ns/1ps
// Module: tsplit_full_tap
// Full-width transposed tap: acc_q <= acc_in + sign-extended product.
// Assumes AW > PW. Advances only when en is high.
module tsplit_full_tap #(
    parameter int AW = 19,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] acc_in,
    input  logic [PW-1:0] prod,
    output logic [AW-1:0] acc_q
);
    logic [AW-1:0] prod_x;

    // sign-extend the product across the partial-sum width
    assign prod_x = {{(AW-PW){prod[PW-1]}}, prod};

    // register the updated partial sum on each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= acc_in + prod_x;
    end
endmodule

// File: rtl/tsplit_low_tap.sv
`timescale 1ns/1ps
// Module: tsplit_low_tap
// Split transposed tap. The product is added only to the KW-bit low field,
// the high field passes through, and the signed carry of the low add goes
// into carry slot SLOT of the travelling carry vector.
// Assumes KW >= PW, so the carry is always in {-1, 0, +1}.
module tsplit_low_tap #(
    parameter int KW   = 16,
    parameter int HW   = 3,
    parameter int PW   = 16,
    parameter int NSPL = 3,
    parameter int SLOT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [KW-1:0]     lo_in,
    input  logic [HW-1:0]     hi_in,
    input  logic [2*NSPL-1:0] cv_in,
    input  logic [PW-1:0]     prod,
    output logic [KW-1:0]     lo_q,
    output logic [HW-1:0]     hi_q,
    output logic [2*NSPL-1:0] cv_q
);
    logic [KW+1:0]     s;
    logic [2*NSPL-1:0] cv_next;

    // narrow add: unsigned low field plus sign-extended product
    always_comb begin
        s = {2'b00, lo_in} + {{(KW+2-PW){prod[PW-1]}}, prod};
        cv_next = cv_in;
        cv_next[2*SLOT +: 2] = s[KW+1:KW];
    end

    // register the low field, the passing high field and the carries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            cv_q <= '0;
        end else if (en) begin
            lo_q <= s[KW-1:0];
            hi_q <= hi_in;
            cv_q <= cv_next;
        end
    end
endmodule

// File: rtl/tsplit_merge.sv
`timescale 1ns/1ps
// Module: tsplit_merge
// Output tap. Folds all stored carries into the high field, then adds the
// tap-0 product and registers the full-width result.
// Assumes AW = HW + KW.
module tsplit_merge #(
    parameter int AW   = 19,
    parameter int KW   = 16,
    parameter int HW   = 3,
    parameter int PW   = 16,
    parameter int NSPL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [KW-1:0]     lo,
    input  logic [HW-1:0]     hi,
    input  logic [2*NSPL-1:0] cv,
    input  logic [PW-1:0]     prod,
    output logic [AW-1:0]     y_q
);
    logic [AW-1:0] csum;
    logic [AW-1:0] y_next;

    // sum the signed carries, scale by the split point, add the fields
    always_comb begin
        csum = '0;
        for (int j = 0; j < NSPL; j++) begin
            csum = csum + {{(AW-2){cv[2*j+1]}}, cv[2*j +: 2]};
        end
        y_next = {hi, lo} + {{(AW-PW){prod[PW-1]}}, prod} + (csum << KW);
    end

    // hold the output between accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n)  y_q <= '0;
        else if (en) y_q <= y_next;
    end
endmodule

// File: rtl/fir_split_tdf.sv
`timescale 1ns/1ps
// Module: fir_split_tdf
// Transposed-form FIR with NTAP fixed coefficients. Taps NTAP-1..SPLIT_AT
// hold full-width partial sums. Taps SPLIT_AT-1..1 carry the sum as a high
// field and a KSPLIT-bit low field plus per-tap carries. Tap 0 merges.
// Assumes 2 <= SPLIT_AT < NTAP and DW+CW <= KSPLIT < AW.
module fir_split_tdf #(
    parameter int NTAP     = 8,
    parameter int DW       = 8,
    parameter int CW       = 8,
    parameter int KSPLIT   = 16,
    parameter int SPLIT_AT = 4,
    parameter logic [NTAP*CW-1:0] COEF =
        {8'd3, 8'hF9, 8'd20, 8'h80, 8'd127, 8'd45, 8'hFF, 8'd9},
    localparam int PW   = DW + CW,
    localparam int AW   = PW + $clog2(NTAP),
    localparam int HW   = AW - KSPLIT,
    localparam int NSPL = SPLIT_AT - 1,
    localparam int CVW  = 2 * NSPL
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_x,
    output logic                 out_vld,
    output logic signed [AW-1:0] out_y
);
    logic [PW-1:0]     prod   [NTAP];
    logic [AW-1:0]     ps     [SPLIT_AT:NTAP-1];
    logic [AW-1:0]     ps_src [SPLIT_AT:NTAP-1];
    logic [KSPLIT-1:0] lo     [1:SPLIT_AT-1];
    logic [HW-1:0]     hi     [1:SPLIT_AT-1];
    logic [CVW-1:0]    cv     [1:SPLIT_AT-1];
    logic [KSPLIT-1:0] lo_src [1:SPLIT_AT-1];
    logic [HW-1:0]     hi_src [1:SPLIT_AT-1];
    logic [CVW-1:0]    cv_src [1:SPLIT_AT-1];
    logic [AW-1:0]     y_q;

    // one constant multiplier per tap
    for (genvar t = 0; t < NTAP; t++) begin : g_mul
        logic signed [PW-1:0] p_s;
        tsplit_cmul #(.DW(DW), .CW(CW), .PW(PW), .COEF_T(COEF[t*CW +: CW]))
            u_mul (.x(in_x), .p(p_s));
        assign prod[t] = p_s;
    end

    // full-width taps nearest the input
    for (genvar t = SPLIT_AT; t < NTAP; t++) begin : g_full
        if (t == NTAP - 1) begin : g_top
            assign ps_src[t] = '0;
        end else begin : g_mid
            assign ps_src[t] = ps[t+1];
        end
        tsplit_full_tap #(.AW(AW), .PW(PW)) u_tap (
            .clk(clk), .rst_n(rst_n), .en(in_vld),
            .acc_in(ps_src[t]), .prod(prod[t]), .acc_q(ps[t]));
    end

    // split taps: the first one cuts the full sum into its two fields
    for (genvar t = 1; t < SPLIT_AT; t++) begin : g_split
        if (t == SPLIT_AT - 1) begin : g_cut
            assign lo_src[t] = ps[SPLIT_AT][KSPLIT-1:0];
            assign hi_src[t] = ps[SPLIT_AT][AW-1:KSPLIT];
            assign cv_src[t] = '0;
        end else begin : g_chain
            assign lo_src[t] = lo[t+1];
            assign hi_src[t] = hi[t+1];
            assign cv_src[t] = cv[t+1];
        end
        tsplit_low_tap #(.KW(KSPLIT), .HW(HW), .PW(PW), .NSPL(NSPL),
                         .SLOT(t-1)) u_tap (
            .clk(clk), .rst_n(rst_n), .en(in_vld),
            .lo_in(lo_src[t]), .hi_in(hi_src[t]), .cv_in(cv_src[t]),
            .prod(prod[t]), .lo_q(lo[t]), .hi_q(hi[t]), .cv_q(cv[t]));
    end

    // output tap: resolve carries and add the tap-0 product
    tsplit_merge #(.AW(AW), .KW(KSPLIT), .HW(HW), .PW(PW), .NSPL(NSPL)) u_merge (
        .clk(clk), .rst_n(rst_n), .en(in_vld),
        .lo(lo[1]), .hi(hi[1]), .cv(cv[1]), .prod(prod[0]), .y_q(y_q));

    assign out_y = y_q;

    // output strobe follows the input strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end
endmodule

// File: rtl/fir_split_tdf_chk.sv
`timescale 1ns/1ps
// Module: fir_split_tdf_chk
// Temporal checks on the strobe, the held output, reset and the carry codes.
module fir_split_tdf_chk #(
    parameter int AW   = 19,
    parameter int NSPL = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic              out_vld,
    input logic [AW-1:0]     out_y,
    input logic [2*NSPL-1:0] cv_tail
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_y == '0)); // R1

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R2

    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_y)); // R4

    for (genvar j = 0; j < NSPL; j++) begin : g_cy
        AST_CARRY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            cv_tail[2*j +: 2] != 2'b10); // R5
    end
endmodule

bind fir_split_tdf fir_split_tdf_chk #(.AW(AW), .NSPL(NSPL)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld),
    .out_y(out_y), .cv_tail(cv[1]));

// File: tb/fir_split_tdf_tb.sv
`timescale 1ns/1ps
module fir_split_tdf_tb;
    localparam int NTAP = 8;
    localparam int AW   = 19;
    localparam logic [63:0] CF =
        {8'd3, 8'hF9, 8'd20, 8'h80, 8'd127, 8'd45, 8'hFF, 8'd9};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [7:0] in_x = '0;
    logic out_vld;
    logic signed [AW-1:0] out_y;

    int nchk = 0;
    int nfail = 0;
    longint hist [NTAP];
    longint yhold = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    fir_split_tdf u_dut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .in_x(in_x), .out_vld(out_vld), .out_y(out_y));

    function automatic longint cf(int k);
        return longint'($signed(CF[k*8 +: 8]));
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < NTAP; k++) hist[k] = 0;
        yhold = 0;
    endtask

    // one cycle: drive at the falling edge, check just after the rising edge
    task automatic step(input logic v, input int x, input string tag);
        @(negedge clk);
        in_vld = v;
        in_x = 8'(x);
        if (v) begin
            for (int k = NTAP - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = x;
            yhold = 0;
            for (int k = 0; k < NTAP; k++) yhold += cf(k) * hist[k];
        end
        @(posedge clk);
        #1;
        check({tag, " R2 strobe"}, longint'(out_vld), longint'(v));
        check(tag, longint'(out_y), yhold);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 out_vld", longint'(out_vld), 0);
        check("R1 out_y", longint'(out_y), 0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
    endtask

    initial begin
        clear_model();
        do_reset();

        // R6: impulse of +1 shows the coefficients in order
        step(1'b1, 1, "R6 impulse");
        for (int k = 1; k < NTAP + 2; k++) step(1'b1, 0, "R6 impulse");
        // R7: impulse of -128 gives full-scale products
        step(1'b1, -128, "R7 neg impulse");
        for (int k = 1; k < NTAP + 2; k++) step(1'b1, 0, "R7 neg impulse");

        // R3 R5: ramp over every input code
        for (int v = -128; v < 128; v++) step(1'b1, v, "R3 ramp");

        // R3 R5: held step at every code fills the whole line with it
        for (int v = -128; v < 128; v++)
            for (int r = 0; r < NTAP + 1; r++) step(1'b1, v, "R5 step");

        // R7 R5: alternating full-scale values
        for (int r = 0; r < 64; r++) step(1'b1, (r % 2) ? 127 : -128, "R7 alternate");

        // R4 R2: pseudo-random samples with idle gaps
        for (int r = 0; r < 3000; r++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2:0] != 3'b000, int'($signed(lfsr[15:8])), "R4 gaps");
        end

        // R1: reset in mid-stream, then an impulse must show no old data
        for (int r = 0; r < NTAP; r++) step(1'b1, 100 - 30 * r, "R3 fill");
        do_reset();
        step(1'b0, 55, "R4 idle after reset");
        step(1'b1, 1, "R1 post-reset impulse");
        for (int k = 1; k < NTAP + 1; k++) step(1'b1, 0, "R1 post-reset impulse");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule